// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer Counter

This block holds a 16-bit up/down timer counter that a processor reaches over an 8-bit bus without ever seeing a torn value. The counter sits behind two byte addresses. The high-byte address never touches the counter directly; it always reaches a shared 8-bit holding register. Reading the low byte captures the counter's upper half into that holding register in the same clock. Writing the low byte moves the holding register and the written byte into the counter together.

Counting is driven by a timer tick, but only while the 3-bit clock-select value is non-zero. On each enabled tick the counter is cleared, stepped up or stepped down. A processor write of the low byte overrides any count or clear in the same cycle. The block reports when the counter equals zero and when it equals a supplied maximum. It also keeps a sticky overflow flag that software clears by writing a one.

Top module: `byte_timer16`

## Requirements
- R1: After reset the counter, the holding register and the overflow flag are all zero.
- R2: A read at address 0 (low byte) returns counter bits 7:0 and copies counter bits 15:8 into the holding register at that clock edge. A read at address 1 (high byte) returns the holding register. A read at address 2 returns 7 zero bits above the overflow flag in bit 0. Read data is combinational from the current state.
- R3: A write at address 1 loads only the holding register and leaves the counter unchanged. A write at address 0 loads {holding register, written byte} into all 16 counter bits at one clock edge.
- R4: A low-byte write takes priority over a tick, a clear and a direction request in the same cycle.
- R5: While the clock select is 0, ticks have no effect on the counter or the overflow flag, and bus reads and writes still work.
- R6: On a tick with a non-zero clock select, the clear request forces the counter to zero. Otherwise the direction input selects +1 (0) or -1 (1), wrapping modulo 2^16.
- R7: The bottom output is high exactly when the counter is zero. The top output is high exactly when the counter equals the top input.
- R8: The overflow flag is set by an enabled up-tick that wraps 0xFFFF to 0x0000. It is also set by an enabled tick with clear requested, direction up, and counter equal to top. A down wrap does not set it.
- R9: The overflow flag stays set until a write at address 2 with bit 0 high. A write with bit 0 low leaves it set. A set event in the same cycle as the clearing write keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | 0 low byte, 1 high byte (holding register), 2 overflow flag |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| tick | input | 1 | Timer tick from the prescaler |
| clkSel | input | 3 | Clock select; 0 stops counting |
| countDown | input | 1 | 1 selects decrement |
| clearReq | input | 1 | Clear the counter on the next enabled tick |
| topVal | input | 16 | Maximum counter value |
| cnt | output | 16 | Counter value |
| atTop | output | 1 | Counter equals topVal |
| atBottom | output | 1 | Counter equals zero |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A corrupted holding register stays hidden until the next high-byte read or low-byte write. At that point it appears as a wrong busRdata, or as a wrong upper counter byte one clock after the write. A wrong counter value shows on cnt, atTop and atBottom at the first clock edge after the fault. A wrong overflow state persists on ovfFlag until a clearing write. The reference model is compared on every clock, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_LOW  = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } addr_e;

  typedef struct packed {
    logic loadLow;   // low-byte write: whole counter load
    logic loadTemp;  // high-byte write into holding register
    logic snapTemp;  // low-byte read: capture upper half
    logic tickEn;    // gated tick
    logic doClear;   // clear on tick
    logic doDown;    // decrement on tick
    logic flagClr;   // software clear of overflow flag
  } strobe_t;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             wdataBit0,
  input  logic             tick,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             countDown,
  input  logic             clearReq,
  output strobe_t          strobes
);
  logic clkRunning;
  logic rdOnly;

  assign clkRunning = |clkSel;
  assign rdOnly     = busRd && !busWr;

  always_comb begin
    strobes          = '0;
    strobes.loadLow  = busWr && (busAddr == ADDR_LOW);
    strobes.loadTemp = busWr && (busAddr == ADDR_HIGH);
    strobes.flagClr  = busWr && (busAddr == ADDR_FLAG) && wdataBit0;
    strobes.snapTemp = rdOnly && (busAddr == ADDR_LOW);
    strobes.tickEn   = tick && clkRunning;
    strobes.doClear  = clearReq;
    strobes.doDown   = countDown;
  end
endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
#(
  parameter int W  = CNT_W,
  localparam int BW = W / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic [1:0]    busAddr,
  input  logic [BW-1:0] busWdata,
  input  logic [W-1:0]  topVal,
  output logic [BW-1:0] busRdata,
  output logic [W-1:0]  cnt,
  output logic          atTop,
  output logic          atBottom,
  output logic          ovfFlag
);
  logic [BW-1:0] tempReg;
  logic [W-1:0]  cntNext;
  logic          ovfSet;
  logic          upWrap;
  logic          topClear;

  assign atTop    = (cnt == topVal);
  assign atBottom = (cnt == '0);

  assign upWrap   = strobes.tickEn && !strobes.doClear && !strobes.doDown && (cnt == '1);
  assign topClear = strobes.tickEn && strobes.doClear && !strobes.doDown && atTop;
  assign ovfSet   = !strobes.loadLow && (upWrap || topClear);

  always_comb begin
    cntNext = cnt;
    if (strobes.loadLow)       cntNext = {tempReg, busWdata};
    else if (strobes.tickEn) begin
      if (strobes.doClear)     cntNext = '0;
      else if (strobes.doDown) cntNext = cnt - 1'b1;
      else                     cntNext = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      tempReg <= '0;
      ovfFlag <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobes.loadTemp)      tempReg <= busWdata;
      else if (strobes.snapTemp) tempReg <= cnt[W-1:BW];
      if (ovfSet)                ovfFlag <= 1'b1;
      else if (strobes.flagClr)  ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_LOW:  busRdata = cnt[BW-1:0];
      ADDR_HIGH: busRdata = tempReg;
      ADDR_FLAG: busRdata = {{(BW-1){1'b0}}, ovfFlag};
      default:   busRdata = '0;
    endcase
  end

  // R2: low-byte read captures the upper half
  p_snap_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snapTemp |=> tempReg == $past(cnt[W-1:BW]));
  // R3: high-byte write leaves the counter alone when nothing else moves it
  p_temp_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadTemp && !strobes.tickEn) |=> $stable(cnt));
  // R4: low-byte write wins over counting
  p_cpu_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLow |=> cnt == {$past(tempReg), $past(busWdata)});
  // R5: without an enabled tick or a load the counter holds
  p_stopped_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tickEn && !strobes.loadLow) |=> $stable(cnt));
  // R6: up-step by one
  p_step_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tickEn && !strobes.loadLow && !strobes.doClear && !strobes.doDown)
      |=> cnt == $past(cnt) + 1'b1);
  // R8: wrap raises the flag
  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (upWrap && !strobes.loadLow) |=> ovfFlag);
  // R9: flag is sticky without a clearing write
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobes.flagClr) |=> ovfFlag);
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import tmr16_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter int SEL_W = 3,
  localparam int BW   = W / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BW-1:0]    busWdata,
  output logic [BW-1:0]    busRdata,
  input  logic             tick,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             countDown,
  input  logic             clearReq,
  input  logic [W-1:0]     topVal,
  output logic [W-1:0]     cnt,
  output logic             atTop,
  output logic             atBottom,
  output logic             ovfFlag
);
  strobe_t strobes;

  tmr16_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .wdataBit0(busWdata[0]),
    .tick(tick), .clkSel(clkSel), .countDown(countDown), .clearReq(clearReq),
    .strobes(strobes)
  );

  tmr16_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .topVal(topVal), .busRdata(busRdata), .cnt(cnt),
    .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/byte_timer16_bench.sv
`timescale 1ns/1ps
module byte_timer16_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd3;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic        tick = 1'b0;
  logic [2:0]  clkSel = 3'd0;
  logic        countDown = 1'b0, clearReq = 1'b0;
  logic [15:0] topVal = 16'h0010;
  logic [15:0] cnt;
  logic        atTop, atBottom, ovfFlag;

  int errors = 0, checks = 0;
  int mCnt = 0, mTemp = 0, mOvf = 0;
  string tag = "R1";
  bit done = 0;
  int seed = 12345;

  always #2.5 clk = ~clk;

  byte_timer16 u_byte_timer16 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .tick(tick), .clkSel(clkSel),
    .countDown(countDown), .clearReq(clearReq), .topVal(topVal), .cnt(cnt),
    .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int modelRd(int a);
    if (a == 0) return mCnt % 256;
    if (a == 1) return mTemp;
    if (a == 2) return mOvf;
    return 0;
  endfunction

  // Drive one cycle: inputs set after negedge, read data checked before edge,
  // model advanced at the edge, outputs compared at the next negedge.
  task automatic cyc(int a, bit wr, bit rd, int wd, bit tk, int cs, bit dn, bit clr);
    int nCnt, nTemp, nOvf;
    bit loadLow, en;
    busAddr = a[1:0]; busWr = wr; busRd = rd; busWdata = wd[7:0];
    tick = tk; clkSel = cs[2:0]; countDown = dn; clearReq = clr;
    #1;
    if (rd) check((a == 2) ? "R9" : "R2", "rdata", int'(busRdata), modelRd(a));
    @(posedge clk);
    loadLow = wr && a == 0;
    en = tk && cs != 0;
    nCnt = mCnt; nTemp = mTemp; nOvf = mOvf;
    if (loadLow) nCnt = mTemp * 256 + wd;
    else if (en) nCnt = clr ? 0 : (dn ? (mCnt + 65535) % 65536 : (mCnt + 1) % 65536);
    if (wr && a == 1) nTemp = wd;
    else if (rd && !wr && a == 0) nTemp = mCnt / 256;
    if (!loadLow && en && !dn && ((clr && mCnt == int'(topVal)) || (!clr && mCnt == 65535)))
      nOvf = 1;
    else if (wr && a == 2 && wd[0]) nOvf = 0;
    mCnt = nCnt; mTemp = nTemp; mOvf = nOvf;
    @(negedge clk);
    check(tag, "cnt", int'(cnt), mCnt);
    check(tag, "ovf", int'(ovfFlag), mOvf);
    check("R7", "atBottom", int'(atBottom), int'(mCnt == 0));
    check("R7", "atTop", int'(atTop), int'(mCnt == int'(topVal)));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(3, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R1";
    idle(1);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);            // R1: holding register zero
    cyc(2, 0, 1, 0, 0, 0, 0, 0);            // R1: flag zero
    // R3: high write alone, then whole load
    tag = "R3";
    cyc(1, 1, 0, 8'hFF, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 8'hFD, 0, 0, 0, 0);        // counter 0xFFFD
    // R8: up wrap sets flag
    tag = "R8";
    for (int i = 0; i < 4; i++) cyc(3, 0, 0, 0, 1, 1, 0, 0);
    cyc(2, 0, 1, 0, 0, 0, 0, 0);
    // R9: write 0 keeps flag, write 1 clears, set beats clear
    tag = "R9";
    cyc(2, 1, 0, 8'hFE, 0, 0, 0, 0);
    cyc(2, 1, 0, 8'h01, 0, 0, 0, 0);
    cyc(2, 0, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 8'hFF, 0, 0, 0, 0);
    cyc(0, 1, 0, 8'hFF, 0, 0, 0, 0);        // 0xFFFF
    cyc(2, 1, 0, 8'h01, 1, 3, 0, 0);        // wrap and clear same cycle
    cyc(2, 0, 1, 0, 0, 0, 0, 0);
    cyc(2, 1, 0, 8'h01, 0, 0, 0, 0);
    // R6: down wrap, no flag; clear wins
    tag = "R6";
    for (int i = 0; i < 3; i++) cyc(3, 0, 0, 0, 1, 2, 1, 0);
    cyc(3, 0, 0, 0, 1, 5, 1, 1);
    cyc(3, 0, 0, 0, 1, 5, 0, 0);
    // R5: ticks ignored while stopped, bus works
    tag = "R5";
    for (int i = 0; i < 4; i++) cyc(3, 0, 0, 0, 1, 0, i % 2, i == 2);
    cyc(1, 1, 0, 8'h12, 1, 0, 0, 0);
    cyc(0, 1, 0, 8'h34, 1, 0, 0, 0);
    // R4: load beats tick and clear
    tag = "R4";
    cyc(1, 1, 0, 8'h00, 0, 0, 0, 0);
    cyc(0, 1, 0, 8'h0F, 1, 7, 0, 1);
    cyc(0, 1, 0, 8'h10, 1, 7, 1, 0);
    // R8: clear at top while counting up
    tag = "R8";
    cyc(3, 0, 0, 0, 1, 1, 0, 1);
    cyc(2, 0, 1, 0, 0, 0, 0, 0);
    cyc(2, 1, 0, 8'h01, 0, 0, 0, 0);
    // R2: snapshot coherent while counting
    tag = "R2";
    cyc(1, 1, 0, 8'h01, 0, 0, 0, 0);
    cyc(0, 1, 0, 8'hFE, 0, 0, 0, 0);        // 0x01FE
    cyc(3, 0, 0, 0, 1, 1, 0, 0);            // 0x01FF
    cyc(0, 0, 1, 0, 1, 1, 0, 0);            // reads FF, temp=01, cnt->0200
    cyc(1, 0, 1, 0, 1, 1, 0, 0);            // reads 01 despite 0x0200
    cyc(3, 0, 0, 0, 1, 1, 0, 0);
    // mixed random traffic
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'h7FFFFFFF;
      cyc(r % 4, (r >> 3) % 5 == 0, (r >> 6) % 3 == 0, (r >> 9) % 256,
          (r >> 17) % 4 != 0, (r >> 19) % 8, (r >> 22) % 3 == 0, (r >> 24) % 9 == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule